// File: doc/BRIEF.md
# Two-Function PCI Request Arbiter

This block lets two internal bus masters, a video engine and an audio engine, share a single PCI request/grant pair. It merges the two internal requests into the external active-low request line. It steers the external grant to exactly one function. Audio has precedence, and the grant parks on video when nobody is asking.

Two control bits select compatibility behaviour. With `lock_en` set, the arbiter latches its choice as soon as the grant arrives. While that choice is held, only the chosen function's request can drive the external request. From the start of the transaction until the bus is idle again, no request is driven at all. With `late_en` set, a grant is forwarded only while the external request is asserted. This removes bus parking, so an initiator cannot start in the cycle where the grant is withdrawn.

All external PCI lines are active-low and are inverted at the block edge. The lock state and the latched winner are held in registers on the PCI clock.

Top module: `pci_dual_arbiter`

## Requirements
- R1: With `lock_en` low, `pci_req_n` is low exactly when `vid_req` or `aud_req` is high, in the same cycle.
- R2: With the bus free and the grant present, an asserted `aud_req` sends the grant to `aud_gnt` rather than `vid_gnt`, whether or not `vid_req` is also high.
- R3: With the bus free, no request pending, `late_en` low and the grant present, the grant goes to `vid_gnt`; this also holds right after reset.
- R4: If audio starts requesting after video but before the grant arrives, audio still receives the grant.
- R5: Once FRAME has been asserted, the function granted in the cycle before FRAME keeps the grant until FRAME and IRDY are both deasserted, even if the other function requests.
- R6: With `lock_en` high, the function selected when the grant first appears is latched at that clock edge. While the lock is held, `pci_req_n` follows only that function's request.
- R7: With `lock_en` high, `pci_req_n` stays high from the cycle after FRAME is seen until the bus returns to idle, whatever either function requests.
- R8: The lock is released at the clock edge where FRAME and IRDY are both deasserted. From the next cycle, `pci_req_n` and the grant steering follow the live requests again.
- R9: With `late_en` high, neither internal grant is asserted while `pci_req_n` is high.
- R10: At most one of `vid_gnt` and `aud_gnt` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_req | input | 1 | Video function bus request, active-high |
| aud_req | input | 1 | Audio function bus request, active-high |
| pci_gnt_n | input | 1 | External PCI grant, active-low |
| pci_frame_n | input | 1 | PCI FRAME, active-low |
| pci_irdy_n | input | 1 | PCI IRDY, active-low |
| lock_en | input | 1 | Enable lock-on-grant mode |
| late_en | input | 1 | Enable grant-only-while-requesting mode |
| pci_req_n | output | 1 | External PCI request, active-low |
| vid_gnt | output | 1 | Grant to video function |
| aud_gnt | output | 1 | Grant to audio function |

## Verification
`pci_req_n` and both internal grants are combinational in the inputs and the held state. The bench therefore drives inputs on the falling clock edge and checks these outputs one time unit later, within the same cycle. Lock capture, transaction ownership and release take effect only at the following rising edge. Each check of those results is made in the cycle after the stimulus that causes them, which is the first cycle where the changed state can be seen at the ports.

// File: rtl/pci_arb_pkg.sv
// Shared types for the two-function PCI request arbiter.
package pci_arb_pkg;
    // Arbitration hold state: free, latched on grant, or transaction running.
    typedef enum logic [1:0] {
        ARB_FREE = 2'd0,
        ARB_HELD = 2'd1,
        ARB_BUSY = 2'd2
    } arb_state_t;

    // Function select encoding used for the winner and the steering choice.
    localparam logic SEL_VIDEO = 1'b0;
    localparam logic SEL_AUDIO = 1'b1;
endpackage

// File: rtl/pci_arb_pins.sv
// Polarity boundary: converts the active-low PCI lines to active-high
// internal signals and back. Assumes no synchronisation is needed, because
// the lines are already on the PCI clock.
module pci_arb_pins (
    input  logic pci_gnt_n,
    input  logic pci_frame_n,
    input  logic pci_irdy_n,
    input  logic req,
    output logic gnt,
    output logic frame,
    output logic irdy,
    output logic pci_req_n
);
    // Invert each line crossing the block boundary.
    always_comb begin
        gnt       = ~pci_gnt_n;
        frame     = ~pci_frame_n;
        irdy      = ~pci_irdy_n;
        pci_req_n = ~req;
    end
endmodule

// File: rtl/pci_arb_lock_fsm.sv
// Ownership tracker. It latches the winning function on grant (lock mode) or
// at transaction start (both modes) and releases when FRAME and IRDY are idle.
// Assumes the initiator raises FRAME in the cycle after it saw its grant.
module pci_arb_lock_fsm
    import pci_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_en,
    input  logic       gnt,
    input  logic       frame,
    input  logic       irdy,
    input  logic       choice,
    output arb_state_t state,
    output logic       winner
);
    logic       sel_q;
    arb_state_t state_d;
    logic       winner_d;
    logic       bus_idle;

    assign bus_idle = !frame && !irdy;

    // Next-state and winner selection for the hold state machine.
    always_comb begin
        state_d  = state;
        winner_d = winner;
        unique case (state)
            ARB_FREE: begin
                if (lock_en && gnt) begin
                    state_d  = ARB_HELD;
                    winner_d = choice;
                end else if (frame) begin
                    state_d  = ARB_BUSY;
                    winner_d = sel_q;
                end
            end
            ARB_HELD: begin
                if (frame || irdy)
                    state_d = ARB_BUSY;
                else if (!gnt)
                    state_d = ARB_FREE;
            end
            ARB_BUSY: begin
                if (bus_idle)
                    state_d = ARB_FREE;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // Register the state, the winner and the previous-cycle steering choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ARB_FREE;
            winner <= SEL_VIDEO;
            sel_q  <= SEL_VIDEO;
        end else begin
            state  <= state_d;
            winner <= winner_d;
            sel_q  <= choice;
        end
    end

    // R5: a running transaction keeps its owner while the bus is busy.
    p_owner_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_BUSY && (frame || irdy)) |=> (state == ARB_BUSY && $stable(winner)));

    // R8: an idle bus during a transaction frees the arbiter at the next edge.
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_BUSY && bus_idle) |=> (state == ARB_FREE));

    // R6: in lock mode, the grant latches the live choice.
    p_lock_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_FREE && lock_en && gnt) |=> (state == ARB_HELD && winner == $past(choice)));
endmodule

// File: rtl/pci_arb_steer.sv
// Request combining and grant steering. While free, audio takes precedence
// and video is the parking target. While held or busy, the latched winner is
// used. Assumes the state and winner come from registered logic.
module pci_arb_steer
    import pci_arb_pkg::*;
(
    input  logic       vid_req,
    input  logic       aud_req,
    input  logic       gnt,
    input  logic       lock_en,
    input  logic       late_en,
    input  arb_state_t state,
    input  logic       winner,
    output logic       req,
    output logic       choice,
    output logic       vid_gnt,
    output logic       aud_gnt
);
    logic held;
    logic gnt_pass;

    // Pick the function that receives the grant.
    always_comb begin
        held   = (state != ARB_FREE);
        choice = held ? winner : (aud_req ? SEL_AUDIO : SEL_VIDEO);
    end

    // Build the external request according to the mode and hold state.
    always_comb begin
        if (!lock_en || state == ARB_FREE)
            req = vid_req || aud_req;
        else if (state == ARB_HELD)
            req = (winner == SEL_AUDIO) ? aud_req : vid_req;
        else
            req = 1'b0;
    end

    // Forward the grant, gated by the request in late-grant mode.
    always_comb begin
        gnt_pass = gnt && (!late_en || req);
        aud_gnt  = gnt_pass && (choice == SEL_AUDIO);
        vid_gnt  = gnt_pass && (choice == SEL_VIDEO);
    end
endmodule

// File: rtl/pci_dual_arbiter.sv
// Top level of the two-function PCI request arbiter. It joins the pin
// polarity stage, the ownership tracker and the steering logic.
// Assumes all inputs are synchronous to clk.
module pci_dual_arbiter
    import pci_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_req,
    input  logic aud_req,
    input  logic pci_gnt_n,
    input  logic pci_frame_n,
    input  logic pci_irdy_n,
    input  logic lock_en,
    input  logic late_en,
    output logic pci_req_n,
    output logic vid_gnt,
    output logic aud_gnt
);
    logic       gnt;
    logic       frame;
    logic       irdy;
    logic       req;
    logic       choice;
    logic       winner;
    arb_state_t state;

    pci_arb_pins u_pins (
        .pci_gnt_n   (pci_gnt_n),
        .pci_frame_n (pci_frame_n),
        .pci_irdy_n  (pci_irdy_n),
        .req         (req),
        .gnt         (gnt),
        .frame       (frame),
        .irdy        (irdy),
        .pci_req_n   (pci_req_n)
    );

    pci_arb_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_en (lock_en),
        .gnt     (gnt),
        .frame   (frame),
        .irdy    (irdy),
        .choice  (choice),
        .state   (state),
        .winner  (winner)
    );

    pci_arb_steer u_steer (
        .vid_req (vid_req),
        .aud_req (aud_req),
        .gnt     (gnt),
        .lock_en (lock_en),
        .late_en (late_en),
        .state   (state),
        .winner  (winner),
        .req     (req),
        .choice  (choice),
        .vid_gnt (vid_gnt),
        .aud_gnt (aud_gnt)
    );

    // R10: never grant both functions.
    p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_gnt, aud_gnt}));

    // R9: late-grant mode forwards nothing while no request is out.
    p_late_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (late_en && pci_req_n) |-> (!vid_gnt && !aud_gnt));

    // R7: lock mode keeps the pin quiet during a transaction.
    p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && state == ARB_BUSY) |-> pci_req_n);

    // R3: a free, idle bus parks the grant on video.
    p_park_video_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_FREE && !pci_gnt_n && !late_en && !vid_req && !aud_req) |-> vid_gnt);
endmodule

// File: tb/tb_pci_dual_arbiter.sv
// Directed bench for the two-function PCI request arbiter.
module tb_pci_dual_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vid_req = 1'b0, aud_req = 1'b0;
    logic pci_gnt_n = 1'b1, pci_frame_n = 1'b1, pci_irdy_n = 1'b1;
    logic lock_en = 1'b0, late_en = 1'b0;
    logic pci_req_n, vid_gnt, aud_gnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pci_dual_arbiter dut (
        .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .aud_req(aud_req),
        .pci_gnt_n(pci_gnt_n), .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
        .lock_en(lock_en), .late_en(late_en),
        .pci_req_n(pci_req_n), .vid_gnt(vid_gnt), .aud_gnt(aud_gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one output bit, counting the check and reporting a mismatch.
    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Check the pin and both grants at once; a grant pair is {vid,aud}.
    task automatic check_all(input string tag, input logic req_n, input logic vg, input logic ag);
        check({tag, " req_n"}, pci_req_n, req_n);
        check({tag, " vid_gnt"}, vid_gnt, vg);
        check({tag, " aud_gnt"}, aud_gnt, ag);
        check({tag, " R10 onehot"}, vid_gnt & aud_gnt, 1'b0);
    endtask

    // Drive all inputs on the falling edge, then settle one time unit.
    task automatic drive(input logic v, input logic a, input logic g, input logic f, input logic i);
        @(negedge clk);
        vid_req = v; aud_req = a;
        pci_gnt_n = ~g; pci_frame_n = ~f; pci_irdy_n = ~i;
        #1;
    endtask

    task automatic idle_bus();
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
    endtask

    // Reset state: grant with no requests parks on video.
    task automatic t_reset();
        drive(0, 0, 1, 0, 0);
        check_all("R3 reset park", 1'b1, 1'b1, 1'b0);
        idle_bus();
    endtask

    // R1: the pin is the OR of both requests in normal mode.
    task automatic t_or();
        lock_en = 0; late_en = 0;
        drive(0, 0, 0, 0, 0); check("R1 none", pci_req_n, 1'b1);
        drive(1, 0, 0, 0, 0); check("R1 vid", pci_req_n, 1'b0);
        drive(0, 1, 0, 0, 0); check("R1 aud", pci_req_n, 1'b0);
        drive(1, 1, 0, 0, 0); check("R1 both", pci_req_n, 1'b0);
        idle_bus();
    endtask

    // R2/R4: audio precedence, including a late audio request.
    task automatic t_priority();
        drive(1, 1, 1, 0, 0); check_all("R2 both", 1'b0, 1'b0, 1'b1);
        idle_bus();
        drive(1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0);
        drive(1, 1, 1, 0, 0); check_all("R4 late audio", 1'b0, 1'b0, 1'b1);
        idle_bus();
    endtask

    // R5/R8: video owns the bus and audio cannot take it until idle.
    task automatic t_no_preempt();
        drive(1, 0, 1, 0, 0); check("R5 video granted", vid_gnt, 1'b1);
        drive(0, 1, 1, 1, 0);
        drive(0, 1, 1, 1, 1); check_all("R5 hold video", 1'b0, 1'b1, 1'b0);
        drive(0, 1, 1, 0, 1); check_all("R5 hold irdy", 1'b0, 1'b1, 1'b0);
        drive(0, 1, 1, 0, 0); check("R5 still busy", vid_gnt, 1'b1);
        drive(0, 1, 1, 0, 0); check_all("R8 audio after idle", 1'b0, 1'b0, 1'b1);
        idle_bus();
    endtask

    // R6/R7/R8: lock mode latches audio and silences the pin in the transaction.
    task automatic t_lock();
        lock_en = 1;
        drive(1, 1, 0, 0, 0); check("R6 or before gnt", pci_req_n, 1'b0);
        drive(1, 1, 1, 0, 0); check("R6 audio chosen", aud_gnt, 1'b1);
        drive(1, 0, 1, 0, 0); check_all("R6 only winner req", 1'b1, 1'b0, 1'b1);
        drive(1, 1, 0, 1, 0); check("R6 winner req drives", pci_req_n, 1'b0);
        drive(1, 1, 0, 1, 1); check("R7 quiet busy", pci_req_n, 1'b1);
        drive(1, 1, 0, 0, 1); check("R7 quiet irdy", pci_req_n, 1'b1);
        drive(1, 1, 0, 0, 0); check("R7 quiet until edge", pci_req_n, 1'b1);
        drive(1, 0, 1, 0, 0); check_all("R8 live after release", 1'b0, 1'b1, 1'b0);
        drive(0, 0, 0, 0, 0);
        idle_bus();
        lock_en = 0;
        idle_bus();
    endtask

    // R9: late-grant mode drops parking and forwards only with a request.
    task automatic t_late();
        late_en = 1;
        drive(0, 0, 1, 0, 0); check_all("R9 no park", 1'b1, 1'b0, 1'b0);
        drive(1, 0, 1, 0, 0); check_all("R9 video req", 1'b0, 1'b1, 1'b0);
        drive(0, 0, 1, 0, 0); check_all("R9 dropped", 1'b1, 1'b0, 1'b0);
        late_en = 0;
        drive(0, 0, 1, 0, 0); check_all("R3 park back", 1'b1, 1'b1, 1'b0);
        idle_bus();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_or();
        t_priority();
        t_no_preempt();
        t_lock();
        t_late();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule